// File: doc/BRIEF.md
# Paired-Register I2C Target Engine

This block is the target side of an I2C-connected register device. It watches oversampled SCL and SDA lines and answers its own 7-bit address. The upper four bits of that address are fixed at `0100` and the lower three come from strap inputs. A write transaction carries a command byte that sets a 3-bit register pointer, followed by any number of data bytes. A read transaction sets the pointer with a command byte, issues a repeated START and then the address with the read bit set, after which the engine returns register bytes MSB first. The engine answers the address, the command byte and every written byte by pulling SDA low during the ninth clock.

The register pointer does not count upward. After every data byte, written or read, it flips its least significant bit, so a transfer ping-pongs between the two registers of a pair (for example 3, 2, 3, 2, ...) for as long as the master keeps going. The register bank sits outside the block. The bank is reached through a byte port: the pointer as an index, a one-cycle write strobe with data, and a read data input that the bank drives from the index.

The pointer keeps its value between transactions, so a read with no new command byte starts wherever the previous transfer left it. A STOP, or a START in the middle of a byte, abandons the byte in progress without writing it. Bytes that were already acknowledged stay written.

Top module: `i2c_pair_target`

## Requirements
- R1: While reset is held and just after it, `sda_pull` is 0, `reg_wr_en` is 0 and `reg_idx` is 0.
- R2: The target pulls SDA low in the ninth clock of an address byte whose upper seven bits equal `{4'b0100, addr_strap}`. For any other address it stays released for that byte and for every following byte until the next START.
- R3: The byte after a write address is the command byte. It is acknowledged and its bits [2:0] load the register pointer; bits [7:3] are ignored.
- R4: Each data byte after the command byte is acknowledged and is committed after the falling SCL edge that ends its acknowledge clock. The commit is a one-cycle `reg_wr_en` pulse with `reg_idx` holding the target register and `reg_wr_data` holding the byte, MSB received first. No write strobe is ever raised during a read.
- R5: After every data byte, written or read, the pointer flips bit 0 (3 is followed by 2, then 3 again). There is no limit on the number of bytes.
- R6: After a repeated START and the address with bit 0 = 1, the target acknowledges and then sends bytes MSB first, the first from the current pointer. Further bytes alternate within the pair for as long as the master acknowledges (SDA low in the ninth clock).
- R7: A read byte is taken from `reg_rd_data` when its transfer begins. A change in the bank while the byte is shifting out does not alter it.
- R8: When the master leaves SDA high in the ninth clock of a read byte (NACK), the target releases SDA and drives nothing more until the next START.
- R9: A STOP ends any transaction and releases SDA. A STOP or START in the middle of a byte discards that byte with no write, and earlier acknowledged bytes keep their values. After a START, the next byte is taken as an address.
- R10: The pointer persists across transactions. A read that is not preceded by a command byte starts from the pointer as the last transfer left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| addr_strap | input | 3 | Low three bits of the target address |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_idx | output | 3 | Register pointer, index into the bank |
| reg_wr_en | output | 1 | One-cycle write strobe to the bank |
| reg_wr_data | output | 8 | Byte to write at `reg_idx` |
| reg_rd_data | input | 8 | Bank contents at `reg_idx` |

## Verification
The checks assume a well-behaved master. SDA changes only while SCL is low, except to form a START or STOP. Each SCL phase lasts much longer than the synchronizer and edge-detect latency. No START is formed while the target itself holds SDA low. The bench master holds every quarter bit for eight clocks and moves SDA a few clocks after SCL has fallen. It releases SDA before every repeated START and STOP, so the properties about when the target pulls or releases SDA, and about strobe spacing, see only legal bus sequences. The bench builds the wired-AND bus itself and models the register bank, so all results are observed at the ports.

// File: rtl/i2c_pt_pkg.sv
package i2c_pt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } pt_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_WDATA
   } pt_phase_e;

endpackage

// File: rtl/i2c_pt_sync.sv
module i2c_pt_sync #(
   parameter int STAGES   = 2,
   parameter int FILT_CYC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      if (STAGES < 2) $error("i2c_pt_sync: STAGES must be at least 2");
      if (FILT_CYC < 0) $error("i2c_pt_sync: FILT_CYC must not be negative");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   generate
      if (FILT_CYC == 0) begin : g_direct
         assign q = chain[STAGES-1];
      end else begin : g_filter
         localparam int FC_W = $clog2(FILT_CYC + 1);
         localparam logic [FC_W-1:0] FC_LIM = FC_W'(FILT_CYC);
         logic [FC_W-1:0] cnt;
         logic            lvl;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
               lvl <= 1'b1;
            end else if (chain[STAGES-1] == lvl) begin
               cnt <= '0;
            end else if (cnt == FC_LIM) begin
               lvl <= chain[STAGES-1];
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign q = lvl;
      end
   endgenerate

endmodule

// File: rtl/i2c_pt_cond.sv
module i2c_pt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_pt_ptr.sv
module i2c_pt_ptr #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] PAIR_BIT = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (adv)  ptr <= ptr ^ PAIR_BIT;
   end

endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target
   import i2c_pt_pkg::*;
#(
   parameter int               ADDR_HI_W   = 4,
   parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b0100,
   parameter int               STRAP_W     = 3,
   parameter int               DATA_W      = 8,
   parameter int               IDX_W       = 3,
   parameter int               SYNC_STAGES = 2,
   parameter int               FILT_CYC    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [STRAP_W-1:0] addr_strap,
   output logic              sda_pull,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   input  logic [DATA_W-1:0] reg_rd_data
);

   localparam int ADDR_W = ADDR_HI_W + STRAP_W;
   localparam int CNT_W  = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   initial begin
      if (ADDR_W != 7)         $error("i2c_pair_target: address must be 7 bits");
      if (DATA_W < ADDR_W + 1) $error("i2c_pair_target: DATA_W too small for address byte");
      if (IDX_W < 1 || IDX_W > DATA_W) $error("i2c_pair_target: IDX_W out of range");
   end

   // line conditioning
   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_pt_sync #(.STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   i2c_pt_sync #(.STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   i2c_pt_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   // pointer
   logic             ptr_load, rd_adv, ptr_adv;
   logic [IDX_W-1:0] cmd_val;

   assign ptr_adv = reg_wr_en | rd_adv;

   i2c_pt_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(cmd_val),
      .adv(ptr_adv), .ptr(reg_idx));

   // transaction engine
   pt_state_e         state;
   pt_phase_e         phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] tx_sh;
   logic              is_read;
   logic              mack_ok;
   logic              addr_hit;

   assign addr_hit = (shreg[ADDR_W:1] == {ADDR_HI, addr_strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         phase       <= PH_ADDR;
         bit_cnt     <= '0;
         shreg       <= '0;
         tx_sh       <= '0;
         is_read     <= 1'b0;
         mack_ok     <= 1'b0;
         sda_pull    <= 1'b0;
         reg_wr_en   <= 1'b0;
         reg_wr_data <= '0;
         ptr_load    <= 1'b0;
         cmd_val     <= '0;
         rd_adv      <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         ptr_load  <= 1'b0;
         rd_adv    <= 1'b0;
         if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            state    <= ST_RX;
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            is_read  <= 1'b0;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise && bit_cnt != BYTE_CNT) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == BYTE_CNT) begin
                     if (phase == PH_ADDR && !addr_hit) begin
                        state <= ST_IDLE;
                     end else begin
                        state    <= ST_ACK;
                        sda_pull <= 1'b1;
                        if (phase == PH_ADDR) is_read <= shreg[0];
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt  <= '0;
                     sda_pull <= 1'b0;
                     case (phase)
                        PH_ADDR: begin
                           if (is_read) begin
                              state    <= ST_TX;
                              tx_sh    <= reg_rd_data;
                              sda_pull <= ~reg_rd_data[DATA_W-1];
                           end else begin
                              state <= ST_RX;
                              phase <= PH_CMD;
                           end
                        end
                        PH_CMD: begin
                           ptr_load <= 1'b1;
                           cmd_val  <= shreg[IDX_W-1:0];
                           phase    <= PH_WDATA;
                           state    <= ST_RX;
                        end
                        PH_WDATA: begin
                           reg_wr_en   <= 1'b1;
                           reg_wr_data <= shreg;
                           state       <= ST_RX;
                        end
                        default: state <= ST_IDLE;
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        state    <= ST_MACK;
                        sda_pull <= 1'b0;
                        rd_adv   <= 1'b1;
                     end else begin
                        bit_cnt  <= bit_cnt + 1'b1;
                        tx_sh    <= tx_sh << 1;
                        sda_pull <= ~tx_sh[DATA_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack_ok <= ~sda_s;
                  if (scl_fall) begin
                     if (mack_ok) begin
                        state    <= ST_TX;
                        bit_cnt  <= '0;
                        tx_sh    <= reg_rd_data;
                        sda_pull <= ~reg_rd_data[DATA_W-1];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_pt_check.sv
module i2c_pt_check
   import i2c_pt_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             stop_det,
   input pt_state_e        state,
   input logic             is_read,
   input logic             sda_pull,
   input logic             reg_wr_en,
   input logic [IDX_W-1:0] reg_idx
);

   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

   // R4: a commit is a single-cycle strobe
   a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R4: no write strobe in a read transaction
   a_r4_no_wr_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> !is_read);

   // R5: every committed byte flips the pair bit of the pointer
   a_r5_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> (reg_idx == ($past(reg_idx) ^ ONE)));

   // R6: the target starts pulling SDA only while SCL is low
   a_r6_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !$past(scl_s));

   // R8: an idle engine never holds SDA
   a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull);

   // R9: STOP releases SDA
   a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   // R9: START releases SDA and restarts address reception
   a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_pull && state == ST_RX));

endmodule

bind i2c_pair_target i2c_pt_check #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .state(state), .is_read(is_read),
   .sda_pull(sda_pull), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx));

// File: tb/sim_i2c_pair_target.sv
`timescale 1ns/1ps
module sim_i2c_pair_target;

   localparam int Q = 8;
   localparam logic [7:0] AW  = 8'h4A;  // {0100,101,0}
   localparam logic [7:0] AR  = 8'h4B;  // {0100,101,1}
   localparam logic [7:0] ABD = 8'h44;  // {0100,010,0}

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] addr_strap = 3'b101;
   logic       sda_pull;
   logic [2:0] reg_idx;
   logic       reg_wr_en;
   logic [7:0] reg_wr_data;
   logic [7:0] reg_rd_data;
   logic       sda_bus;

   logic [7:0] regs [8];
   int         wr_count = 0;
   logic       poke_tog = 1'b0;
   logic       poke_seen = 1'b0;
   logic [2:0] poke_idx = '0;
   logic [7:0] poke_val = '0;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign sda_bus     = m_sda & ~sda_pull;
   assign reg_rd_data = regs[reg_idx];

   i2c_pair_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
      .addr_strap(addr_strap), .sda_pull(sda_pull), .reg_idx(reg_idx),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data));

   // bench register bank
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) regs[i] <= 8'hA0 + 8'(i);
      end else begin
         if (reg_wr_en) begin
            regs[reg_idx] <= reg_wr_data;
            wr_count <= wr_count + 1;
         end
         if (poke_tog != poke_seen) begin
            regs[poke_idx] <= poke_val;
            poke_seen <= poke_tog;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_sda = 1'b1; m_scl = 1'b1; w(Q);
      m_sda = 1'b0; w(Q);
      m_scl = 1'b0;
   endtask

   task automatic bus_rstart;
      w(2); m_sda = 1'b1; w(Q);
      m_scl = 1'b1; w(Q);
      m_sda = 1'b0; w(Q);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop;
      w(2); m_sda = 1'b0; w(Q);
      m_scl = 1'b1; w(Q);
      m_sda = 1'b1; w(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         w(2); m_sda = b[i]; w(Q);
         m_scl = 1'b1; w(Q);
         m_scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      w(2); m_sda = 1'b1; w(Q);
      m_scl = 1'b1; w(Q);
      ack = ~sda_bus;
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(input logic ack_it, input bit poke, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         w(Q); m_scl = 1'b1; w(Q);
         b[i] = sda_bus;
         m_scl = 1'b0;
         if (poke && i == 4) poke_tog = ~poke_tog;
      end
      w(Q); m_sda = ~ack_it; w(Q);
      m_scl = 1'b1; w(Q);
      m_scl = 1'b0; w(2);
      m_sda = 1'b1;
   endtask

   task automatic t_reset;
      chk("R1 sda_pull", 32'(sda_pull), 0);
      chk("R1 reg_wr_en", 32'(reg_wr_en), 0);
      chk("R1 reg_idx", 32'(reg_idx), 0);
   endtask

   task automatic t_bad_addr;
      logic a; int wc = wr_count;
      bus_start;
      send_byte(ABD, a); chk("R2 foreign address not acked", 32'(a), 0);
      send_byte(8'h03, a); chk("R2 following byte ignored", 32'(a), 0);
      send_byte(8'h55, a); chk("R2 data ignored", 32'(a), 0);
      bus_stop;
      chk("R2 no write", 32'(wr_count - wc), 0);
      chk("R2 bank untouched", 32'(regs[3]), 32'hA3);
   endtask

   task automatic t_write_pair;
      logic a; int wc = wr_count;
      bus_start;
      send_byte(AW, a);    chk("R2 own address acked", 32'(a), 1);
      send_byte(8'h03, a); chk("R3 command acked", 32'(a), 1);
      send_byte(8'h11, a); chk("R4 data acked", 32'(a), 1);
      send_byte(8'h22, a); chk("R4 data acked", 32'(a), 1);
      send_byte(8'h33, a); chk("R4 data acked", 32'(a), 1);
      bus_stop;
      chk("R4 write count", 32'(wr_count - wc), 3);
      chk("R5 reg3 final", 32'(regs[3]), 32'h33);
      chk("R5 reg2 written second", 32'(regs[2]), 32'h22);
   endtask

   task automatic t_cmd_upper;
      logic a;
      bus_start;
      send_byte(AW, a);
      send_byte(8'hF6, a); chk("R3 command with high bits acked", 32'(a), 1);
      send_byte(8'h5A, a);
      bus_stop;
      chk("R3 low bits select reg6", 32'(regs[6]), 32'h5A);
      chk("R3 reg7 untouched", 32'(regs[7]), 32'hA7);
   endtask

   task automatic t_long;
      logic a; int wc = wr_count;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h00, a);
      for (int k = 0; k < 12; k++) send_byte(8'h40 + 8'(k), a);
      bus_stop;
      chk("R5 long write count", 32'(wr_count - wc), 12);
      chk("R5 reg0 last even byte", 32'(regs[0]), 32'h4A);
      chk("R5 reg1 last odd byte", 32'(regs[1]), 32'h4B);
   endtask

   task automatic t_read;
      logic a; logic [7:0] b;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h02, a);
      bus_rstart;
      send_byte(AR, a);    chk("R6 read address acked", 32'(a), 1);
      recv_byte(1'b1, 0, b); chk("R6 first byte reg2", 32'(b), 32'h22);
      recv_byte(1'b1, 0, b); chk("R5 second byte reg3", 32'(b), 32'h33);
      recv_byte(1'b0, 0, b); chk("R5 third byte reg2", 32'(b), 32'h22);
      w(Q);
      chk("R8 released after NACK", 32'(sda_pull), 0);
      m_scl = 1'b1; w(Q);
      chk("R8 no drive on extra clock", 32'(sda_bus), 1);
      m_scl = 1'b0;
      bus_stop;
   endtask

   task automatic t_latch;
      logic a; logic [7:0] b;
      poke_idx = 3'd1; poke_val = 8'hEE;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h01, a);
      bus_rstart;
      send_byte(AR, a);
      recv_byte(1'b0, 1, b);
      bus_stop;
      chk("R7 byte latched at start", 32'(b), 32'h4B);
      chk("R7 bank did change", 32'(regs[1]), 32'hEE);
   endtask

   task automatic t_persist;
      logic a; logic [7:0] b;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h05, a);
      bus_stop;
      bus_start;
      send_byte(AR, a); chk("R10 read-only address acked", 32'(a), 1);
      recv_byte(1'b0, 0, b);
      bus_stop;
      chk("R10 read starts at stored pointer", 32'(b), 32'hA5);
      bus_start;
      send_byte(AR, a);
      recv_byte(1'b0, 0, b);
      bus_stop;
      chk("R10 pointer kept its toggle", 32'(b), 32'hA4);
   endtask

   task automatic t_mid_stop;
      logic a; int wc = wr_count;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h00, a);
      send_byte(8'h77, a);
      send_bits(8'h99, 4);
      bus_stop;
      chk("R9 one write before stop", 32'(wr_count - wc), 1);
      chk("R9 completed byte kept", 32'(regs[0]), 32'h77);
      chk("R9 partial byte dropped", 32'(regs[1]), 32'hEE);
      chk("R9 released after stop", 32'(sda_pull), 0);
   endtask

   task automatic t_mid_start;
      logic a; int wc = wr_count;
      bus_start;
      send_byte(AW, a);
      send_byte(8'h04, a);
      send_bits(8'hC3, 5);
      bus_rstart;
      send_byte(AW, a);    chk("R9 address after mid-byte start", 32'(a), 1);
      send_byte(8'h07, a);
      send_byte(8'h3C, a);
      bus_stop;
      chk("R9 one write after restart", 32'(wr_count - wc), 1);
      chk("R9 new transaction wrote reg7", 32'(regs[7]), 32'h3C);
      chk("R9 reg4 untouched", 32'(regs[4]), 32'hA4);
   endtask

   initial begin
      w(5);
      t_reset;
      rst_n = 1'b1;
      w(5);
      t_reset;
      t_bad_addr;
      t_write_pair;
      t_cmd_upper;
      t_long;
      t_read;
      t_latch;
      t_persist;
      t_mid_stop;
      t_mid_start;
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule